// File: doc/BRIEF.md
# Configurable External Interrupt Detector

This block turns one asynchronous external pin into an interrupt request. A two-bit sense-control input selects how the pin is interpreted. In low-level mode the request follows the synchronised pin directly: it is active while the pin is low and keeps asserting for as long as the pin stays low. In the any-change, falling-edge and rising-edge modes a detected event sets a sticky request flag, and the request stays set until it is serviced.

The flag has two clear paths. Software writes a one to the flag bit through a write strobe. The interrupt sequencer pulses an acknowledge when it takes the vector. The block looks only at the pin's level and has no direction input. A pin that the chip itself drives as an output therefore raises requests like any other, which gives software a way to trigger an interrupt. The pin passes through a synchroniser first. Edges are found by comparing each synchronised sample with the one before it. That comparison is blanked while the synchroniser is refilling after reset and in any cycle in which the sense mode changes.

No data stream crosses this block, so every port is a plain control or status signal without a valid/ready handshake.

Top module: `ext_irq_detect`

## Requirements
- R1: After reset is released with the pin held high, `irq_o` and `flag_o` are both 0.
- R2: Sense encoding 00 selects low level. In that mode `irq_o` is the inverse of the pin as seen two rising clock edges later. It stays high for every cycle the pin stays low, and `flag_o` is never set.
- R3: Sense encoding 01 selects any change. Both a rise and a fall of the pin set `flag_o`, which becomes visible after the third rising edge following the pin change.
- R4: Sense encoding 10 selects falling edge. Only a high-to-low pin transition sets `flag_o`, with the same three-edge latency.
- R5: Sense encoding 11 selects rising edge. Only a low-to-high pin transition sets `flag_o`, with the same three-edge latency.
- R6: In modes 01, 10 and 11, `irq_o` equals `flag_o`, and a set flag holds until one of the clear paths acts.
- R7: A clock edge that samples `clr_we_i`=1 with `clr_bit_i`=1 clears the flag. With `clr_bit_i`=0 the write leaves the flag unchanged.
- R8: A clock edge that samples `ack_i`=1 clears the flag.
- R9: When a new event and a clear (write-one or acknowledge) fall on the same clock edge, the flag ends up set.
- R10: No event is reported from the cycles in which the synchroniser refills after reset, or from a cycle in which the sense input differs from its value on the previous clock. A pin held low through reset therefore sets no flag, and an edge that reaches the comparator in the cycle of a mode change is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | External pin level, asynchronous |
| sense_i | input | 2 | Sense mode: 00 low, 01 change, 10 fall, 11 rise |
| clr_we_i | input | 1 | Software write strobe to the flag bit |
| clr_bit_i | input | 1 | Data written; 1 clears the flag, 0 does nothing |
| ack_i | input | 1 | Acknowledge pulse from the interrupt sequencer |
| irq_o | output | 1 | Interrupt request |
| flag_o | output | 1 | Stored event flag |

## Verification
The hardest case to reach is a clear that lands on exactly the edge where an event enters the flag. The event only appears after the pin has crossed the synchroniser and the comparator, so the bench counts those three edges from its own pin drive and raises the clear strobe on the negative edge just before the third. A mode change that coincides with an edge reaching the comparator is timed the same way. The pin is changed two edges before the sense input is switched.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;
endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q[0] <= din;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/extirq_event.sv
module extirq_event
  import extirq_pkg::*;
#(
  parameter int   SYNC_STAGES = 2,
  parameter logic RST_VAL     = 1'b1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   smp,
  input  sense_e sense,
  output logic   evt,
  output logic   lvl_req
);
  localparam int BW = $clog2(SYNC_STAGES + 2);
  localparam logic [BW-1:0] BLANK_INIT = BW'(SYNC_STAGES + 1);

  logic          prev_q;
  sense_e        sense_q;
  logic [BW-1:0] blank_q;
  logic          mode_chg;
  logic          rise, fall, raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= RST_VAL;
      sense_q <= SENSE_LOW;
      blank_q <= BLANK_INIT;
    end else begin
      prev_q  <= smp;
      sense_q <= sense;
      if (blank_q != '0) blank_q <= blank_q - 1'b1;
    end
  end

  assign mode_chg = (sense != sense_q);
  assign rise     = smp & ~prev_q;
  assign fall     = ~smp & prev_q;

  always_comb begin
    unique case (sense)
      SENSE_ANY:  raw = rise | fall;
      SENSE_FALL: raw = fall;
      SENSE_RISE: raw = rise;
      default:    raw = 1'b0;
    endcase
  end

  assign evt     = raw & ~mode_chg & (blank_q == '0);
  assign lvl_req = ~smp;
endmodule

// File: rtl/extirq_flag.sv
module extirq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr_we,
  input  logic clr_bit,
  input  logic ack,
  output logic flag
);
  logic clr;
  assign clr = (clr_we & clr_bit) | ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
  import extirq_pkg::*;
#(
  parameter int   SYNC_STAGES = 2,
  parameter logic PIN_IDLE    = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic [1:0] sense_i,
  input  logic       clr_we_i,
  input  logic       clr_bit_i,
  input  logic       ack_i,
  output logic       irq_o,
  output logic       flag_o
);
  sense_e sense;
  logic   pin_s;
  logic   evt;
  logic   lvl_req;

  assign sense = sense_e'(sense_i);

  extirq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pin_i), .dout(pin_s)
  );

  extirq_event #(.SYNC_STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_event (
    .clk(clk), .rst_n(rst_n), .smp(pin_s), .sense(sense),
    .evt(evt), .lvl_req(lvl_req)
  );

  extirq_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set(evt), .clr_we(clr_we_i),
    .clr_bit(clr_bit_i), .ack(ack_i), .flag(flag_o)
  );

  assign irq_o = (sense == SENSE_LOW) ? lvl_req : flag_o;
endmodule

// File: rtl/extirq_chk.sv
module extirq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] sense_i,
  input logic       clr_we_i,
  input logic       clr_bit_i,
  input logic       ack_i,
  input logic       irq_o,
  input logic       flag_o,
  input logic       pin_s,
  input logic       evt
);
  AST_LEVEL_FOLLOWS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_i == 2'b00) |-> (irq_o == !pin_s)); // R2
  AST_LEVEL_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_i == 2'b00) |-> !evt); // R2
  AST_EDGE_IRQ_IS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_i != 2'b00) |-> (irq_o == flag_o)); // R6
  AST_NO_SPONTANEOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_o && !evt) |=> !flag_o); // R6
  AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && clr_we_i && !clr_bit_i && !ack_i) |=> flag_o); // R7
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && ack_i && !evt) |=> !flag_o); // R8
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag_o); // R9
  AST_MODE_CHANGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_i != $past(sense_i)) |-> !evt); // R10
endmodule

bind ext_irq_detect extirq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sense_i(sense_i), .clr_we_i(clr_we_i),
  .clr_bit_i(clr_bit_i), .ack_i(ack_i), .irq_o(irq_o), .flag_o(flag_o),
  .pin_s(pin_s), .evt(evt)
);

// File: tb/ext_irq_detect_test.sv
module ext_irq_detect_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_i = 1'b1;
  logic [1:0] sense_i = 2'b00;
  logic       clr_we_i = 1'b0;
  logic       clr_bit_i = 1'b0;
  logic       ack_i = 1'b0;
  logic       irq_o, flag_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ext_irq_detect uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .sense_i(sense_i),
    .clr_we_i(clr_we_i), .clr_bit_i(clr_bit_i), .ack_i(ack_i),
    .irq_o(irq_o), .flag_o(flag_o)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic pin_lvl, input logic [1:0] mode);
    rst_n = 1'b0; pin_i = pin_lvl; sense_i = mode;
    clr_we_i = 1'b0; clr_bit_i = 1'b0; ack_i = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(6);
  endtask

  task automatic pulse_ack();
    ack_i = 1'b1; step(1); ack_i = 1'b0;
  endtask

  initial begin
    // R1 reset state
    do_reset(1'b1, 2'b00);
    check(irq_o, 1'b0, "R1 irq");
    check(flag_o, 1'b0, "R1 flag");

    // R2 level mode: latency two edges, holds while low, no flag
    pin_i = 1'b0;
    step(1); check(irq_o, 1'b0, "R2 not yet");
    step(1); check(irq_o, 1'b1, "R2 asserted");
    for (int k = 0; k < 8; k++) begin
      step(1); check(irq_o, 1'b1, "R2 repeats while low");
    end
    check(flag_o, 1'b0, "R2 no flag");
    pin_i = 1'b1;
    step(1); check(irq_o, 1'b1, "R2 still one edge");
    step(1); check(irq_o, 1'b0, "R2 released");

    // R3 R4 R5 sweep: all edge modes, both directions
    for (int m = 1; m < 4; m++) begin
      for (int d = 0; d < 2; d++) begin
        logic exp;
        string tag;
        tag = (m == 1) ? "R3" : (m == 2) ? "R4" : "R5";
        exp = (m == 1) || (m == 2 && d == 0) || (m == 3 && d == 1);
        do_reset(d == 0, 2'(m));
        check(flag_o, 1'b0, {tag, " settled"});
        pin_i = (d == 1);
        step(2); check(flag_o, 1'b0, {tag, " before latency"});
        step(1); check(flag_o, exp, {tag, " detect"});
        check(irq_o, exp, {tag, " R6 irq mirrors flag"});
        step(10); check(flag_o, exp, {tag, " R6 persists"});
      end
    end

    // R7 write-zero keeps, write-one clears
    do_reset(1'b1, 2'b10);
    pin_i = 1'b0; step(4);
    check(flag_o, 1'b1, "R7 setup");
    clr_we_i = 1'b1; clr_bit_i = 1'b0; step(1);
    clr_we_i = 1'b0; step(1);
    check(flag_o, 1'b1, "R7 zero write ignored");
    clr_we_i = 1'b1; clr_bit_i = 1'b1; step(1);
    clr_we_i = 1'b0; clr_bit_i = 1'b0;
    check(flag_o, 1'b0, "R7 one write clears");
    check(irq_o, 1'b0, "R7 irq drops");

    // R8 acknowledge clears
    pin_i = 1'b1; step(4);
    pin_i = 1'b0; step(4);
    check(flag_o, 1'b1, "R8 setup");
    pulse_ack();
    check(flag_o, 1'b0, "R8 ack clears");

    // R9 event and write-one clear on the same edge
    do_reset(1'b1, 2'b01);
    pin_i = 1'b0; step(4);
    check(flag_o, 1'b1, "R9 setup");
    pin_i = 1'b1; step(2);
    clr_we_i = 1'b1; clr_bit_i = 1'b1; step(1);
    clr_we_i = 1'b0; clr_bit_i = 1'b0;
    check(flag_o, 1'b1, "R9 event beats write clear");
    // R9 event and acknowledge on the same edge
    pin_i = 1'b0; step(2);
    ack_i = 1'b1; step(1); ack_i = 1'b0;
    check(flag_o, 1'b1, "R9 event beats ack");

    // R10 pin low through reset in change mode
    do_reset(1'b0, 2'b01);
    check(flag_o, 1'b0, "R10 no flag after reset");
    // R10 edge reaches comparator in mode-change cycle
    do_reset(1'b1, 2'b11);
    pin_i = 1'b0; step(2);
    sense_i = 2'b01; step(1);
    step(3);
    check(flag_o, 1'b0, "R10 edge dropped on mode change");
    pin_i = 1'b1; step(3);
    check(flag_o, 1'b1, "R10 detection resumes");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule